// File: doc/BRIEF.md
# Frame Transmit Sequencer

This block runs the transmission of a single frame held in the normal transmit buffer. A normal request goes through a simplified CSMA-CA loop: a random backoff, then a clear channel assessment, then the PHY start strobe. When the frame asks for an acknowledgement, the block waits for the acknowledgement outcome. If the acknowledgement times out, the block starts a fresh channel-access attempt, up to a configured retry limit. Each normal or scheduled transmission ends with a one-cycle done pulse and a status code.

A scheduled request takes a different path. It waits for an external free-running microsecond clock to equal a target time, then starts the PHY at once. It does no backoff and no retries. A channel check before the start happens only when a configuration input enables it. If the schedule cannot be honoured, the block raises a separate error pulse instead of transmitting.

Random backoff values come from an internal LFSR. The backoff unit period and the length of the channel assessment are parameters, counted in clock cycles.

Top module: `txseq_top`

## Requirements
- R1: A normal trigger starts a backoff of 0 to 7 unit periods, because the backoff exponent starts at 3. A channel assessment follows, and on a clear channel `phyStart` pulses for one cycle.
- R2: The channel is judged busy by `ccaMode` as follows: 1 means busy when `edBusy` is set; 2 means busy when `csBusy` is set; 3 means busy when either is set; 4 means busy only when both are set; any other value means the channel is clear.
- R3: Each busy assessment in normal mode raises the exponent by one, up to a maximum of 5, and draws a new backoff. The fourth busy assessment ends the request with status 1 and no `phyStart`.
- R4: `doneIrq` is a one-cycle pulse that comes with `doneStatus`, coded 0 success, 1 channel access failure, 2 no acknowledgement, 3 grant lost. It never coincides with `schedErrIrq`, and the block is idle while it is high. All outputs are 0 after reset.
- R5: With `ackReq` set, the block raises `ackWait` after `phyDone` and waits. `ackRcvd` ends the request with status 0. In normal mode, `ackTimeout` starts a new attempt with the exponent back at 3, up to `maxRetries` retransmissions. After the last one, the status is 2, so there are `maxRetries`+1 starts in total.
- R6: With `ackReq` clear, `phyDone` ends the request with status 0 on the next cycle, and `ackWait` never rises.
- R7: `expectEnhAck` is 1 while the block is busy if `frameVer` was 2 at the trigger. It is 0 for versions 0 and 1.
- R8: On a scheduled trigger, when (`targetUs` − `nowUs`) mod 2^32, read as signed, is negative or below `minSetupUs`, `schedErrIrq` pulses on the next cycle. No start follows, and the block stays idle.
- R9: At the cycle where `nowUs` equals `targetUs`, if `macBusy` is set or `phyGrant` is clear, `schedErrIrq` pulses instead of a start. Before that instant the grant is not checked.
- R10: A scheduled transmission does no backoff. With `schedCcaEn` clear, `phyStart` is seen one cycle after the clock match. With it set, one assessment runs first, and a busy channel gives status 1.
- R11: A scheduled transmission with an acknowledgement timeout ends with status 2 after a single start.
- R12: Losing `phyGrant` while in backoff, assessment, transmit or acknowledgement wait ends the request on the next cycle with status 3.
- R13: Triggers that arrive while the block is busy are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| trigNormal | input | 1 | Start a normal CSMA-CA transmission |
| trigSched | input | 1 | Start a scheduled transmission |
| ackReq | input | 1 | Frame requests an acknowledgement |
| frameVer | input | 2 | Frame version |
| ccaMode | input | 3 | Channel assessment mode |
| schedCcaEn | input | 1 | Assess channel before a scheduled start |
| edBusy | input | 1 | Energy detector over threshold |
| csBusy | input | 1 | Carrier sense detected |
| phyGrant | input | 1 | PHY access granted |
| macBusy | input | 1 | MAC busy receiving or sending |
| phyDone | input | 1 | PHY finished sending the frame |
| ackRcvd | input | 1 | Acknowledgement received strobe |
| ackTimeout | input | 1 | Acknowledgement wait expired strobe |
| nowUs | input | 32 | Free-running microsecond clock |
| targetUs | input | 32 | Scheduled start time |
| minSetupUs | input | 32 | Minimum lead time for a scheduled request |
| maxRetries | input | 3 | Retransmission limit |
| phyStart | output | 1 | PHY start strobe |
| ackWait | output | 1 | Waiting for an acknowledgement |
| expectEnhAck | output | 1 | Expected acknowledgement is enhanced |
| doneIrq | output | 1 | Transmission finished pulse |
| doneStatus | output | 2 | Completion status code |
| schedErrIrq | output | 1 | Schedule could not be met pulse |
| busy | output | 1 | Sequencer not idle |

## Verification
A sequencer stuck in a wrong state shows up first in the count of `phyStart` pulses per request: a lost retry counter gives too many or too few starts, and a skipped assessment gives a start on a busy channel. A wrong backoff exponent shows up as a start or a failure outside the bounds that the capped exponent allows, within a few hundred cycles. A wrong schedule comparison shows up one cycle after the trigger, as a spurious or missing error pulse, or as a start that is off by one microsecond from the target.

// File: rtl/txseq_pkg.sv
package txseq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SCHED,
    ST_BACKOFF,
    ST_CCA,
    ST_TX,
    ST_ACKWAIT
  } seqState_t;

  localparam logic [1:0] STAT_OK    = 2'd0;
  localparam logic [1:0] STAT_CHAN  = 2'd1;
  localparam logic [1:0] STAT_NOACK = 2'd2;
  localparam logic [1:0] STAT_GRANT = 2'd3;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;
    logic startAttempt;
    logic loadBackoff;
    logic runBackoff;
    logic clrCca;
    logic runCca;
    logic busyStep;
    logic retryStep;
  } dpCmd_t;

  // conditions from datapath to control
  typedef struct packed {
    logic backoffDone;
    logic ccaLast;
    logic chanBusy;
    logic busyLimit;
    logic retryLimit;
    logic late;
    logic timeHit;
  } dpFlag_t;

endpackage

// File: rtl/txseq_dp.sv
module txseq_dp
  import txseq_pkg::*;
#(
  parameter int UNIT_CYCLES = 320,
  parameter int CCA_CYCLES  = 128,
  parameter int BE_MIN      = 3,
  parameter int BE_MAX      = 5,
  parameter int MAX_BUSY    = 4,
  parameter int RETRY_W     = 3,
  parameter int TIME_W      = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  dpCmd_t             cmd,
  input  logic [1:0]         frameVer,
  input  logic [2:0]         ccaMode,
  input  logic               edBusy,
  input  logic               csBusy,
  input  logic [TIME_W-1:0]  nowUs,
  input  logic [TIME_W-1:0]  targetUs,
  input  logic [TIME_W-1:0]  minSetupUs,
  input  logic [RETRY_W-1:0] maxRetries,
  output dpFlag_t            flags,
  output logic               enhKind
);

  localparam int CNT_MAX  = (UNIT_CYCLES > CCA_CYCLES) ? UNIT_CYCLES : CCA_CYCLES;
  localparam int CNT_W    = $clog2(CNT_MAX + 1);
  localparam int BE_W     = $clog2(BE_MAX + 1);
  localparam int UNITS_W  = BE_MAX;
  localparam int NB_W     = $clog2(MAX_BUSY + 1);
  localparam int LFSR_W   = 16;
  localparam logic [CNT_W-1:0]  UNIT_LAST = CNT_W'(UNIT_CYCLES - 1);
  localparam logic [CNT_W-1:0]  CCA_LAST  = CNT_W'(CCA_CYCLES - 1);
  localparam logic [BE_W-1:0]   BE_LO     = BE_W'(BE_MIN);
  localparam logic [BE_W-1:0]   BE_HI     = BE_W'(BE_MAX);
  localparam logic [NB_W-1:0]   NB_LAST   = NB_W'(MAX_BUSY - 1);
  localparam logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1;

  logic [LFSR_W-1:0]  lfsr;
  logic [BE_W-1:0]    be, beNext;
  logic [NB_W-1:0]    nb;
  logic [RETRY_W-1:0] retryCnt;
  logic [UNITS_W-1:0] unitLeft, beMask;
  logic [CNT_W-1:0]   tick;
  logic [TIME_W-1:0]  lead;

  // free-running pseudo-random source
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) lfsr <= LFSR_SEED;
    else       lfsr <= {lfsr[LFSR_W-2:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  end

  // exponent as it will be after this cycle's strobes
  always_comb begin
    if (cmd.startAttempt)  beNext = BE_LO;
    else if (cmd.busyStep) beNext = (be == BE_HI) ? be : be + BE_W'(1);
    else                   beNext = be;
  end

  always_comb begin
    for (int i = 0; i < UNITS_W; i++) beMask[i] = (i < int'(beNext));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      be       <= BE_LO;
      nb       <= '0;
      retryCnt <= '0;
      enhKind  <= 1'b0;
    end else begin
      be <= beNext;
      if (cmd.startAttempt)  nb <= '0;
      else if (cmd.busyStep) nb <= nb + NB_W'(1);
      if (cmd.capture) begin
        retryCnt <= '0;
        enhKind  <= (frameVer == 2'd2);
      end else if (cmd.retryStep) begin
        retryCnt <= retryCnt + RETRY_W'(1);
      end
    end
  end

  // shared cycle counter for unit periods and assessment window
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      unitLeft <= '0;
      tick     <= '0;
    end else if (cmd.loadBackoff) begin
      unitLeft <= lfsr[UNITS_W-1:0] & beMask;
      tick     <= '0;
    end else if (cmd.clrCca) begin
      tick <= '0;
    end else if (cmd.runBackoff && unitLeft != '0) begin
      if (tick == UNIT_LAST) begin
        tick     <= '0;
        unitLeft <= unitLeft - UNITS_W'(1);
      end else begin
        tick <= tick + CNT_W'(1);
      end
    end else if (cmd.runCca) begin
      tick <= tick + CNT_W'(1);
    end
  end

  always_comb begin
    unique case (ccaMode)
      3'd1:    flags.chanBusy = edBusy;
      3'd2:    flags.chanBusy = csBusy;
      3'd3:    flags.chanBusy = edBusy | csBusy;
      3'd4:    flags.chanBusy = edBusy & csBusy;
      default: flags.chanBusy = 1'b0;
    endcase
  end

  assign lead              = targetUs - nowUs;
  assign flags.late        = lead[TIME_W-1] | (lead < minSetupUs);
  assign flags.timeHit     = (nowUs == targetUs);
  assign flags.backoffDone = (unitLeft == '0);
  assign flags.ccaLast     = (tick == CCA_LAST);
  assign flags.busyLimit   = (nb == NB_LAST);
  assign flags.retryLimit  = (retryCnt == maxRetries);

endmodule

// File: rtl/txseq_ctrl.sv
module txseq_ctrl
  import txseq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       trigNormal,
  input  logic       trigSched,
  input  logic       ackReq,
  input  logic       schedCcaEn,
  input  logic       phyGrant,
  input  logic       macBusy,
  input  logic       phyDone,
  input  logic       ackRcvd,
  input  logic       ackTimeout,
  input  dpFlag_t    flags,
  output dpCmd_t     cmd,
  output logic       phyStart,
  output logic       doneIrq,
  output logic [1:0] doneStatus,
  output logic       schedErrIrq,
  output logic       busy,
  output logic       ackWait
);

  seqState_t state, stateN;
  logic isSched, isSchedN, ackReqR, ackReqN;
  logic startPulse, finish, errPulse, usesPhy;
  logic [1:0] finStat;

  assign usesPhy = (state == ST_BACKOFF) || (state == ST_CCA) ||
                   (state == ST_TX) || (state == ST_ACKWAIT);

  always_comb begin
    stateN     = state;
    isSchedN   = isSched;
    ackReqN    = ackReqR;
    cmd        = '0;
    startPulse = 1'b0;
    finish     = 1'b0;
    finStat    = STAT_OK;
    errPulse   = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (trigNormal) begin
          cmd.capture      = 1'b1;
          cmd.startAttempt = 1'b1;
          cmd.loadBackoff  = 1'b1;
          isSchedN         = 1'b0;
          ackReqN          = ackReq;
          stateN           = ST_BACKOFF;
        end else if (trigSched) begin
          if (flags.late) begin
            errPulse = 1'b1;
          end else begin
            cmd.capture = 1'b1;
            isSchedN    = 1'b1;
            ackReqN     = ackReq;
            stateN      = ST_SCHED;
          end
        end
      end
      ST_SCHED: begin
        if (flags.timeHit) begin
          if (macBusy || !phyGrant) begin
            errPulse = 1'b1;
            stateN   = ST_IDLE;
          end else if (schedCcaEn) begin
            cmd.clrCca = 1'b1;
            stateN     = ST_CCA;
          end else begin
            startPulse = 1'b1;
            stateN     = ST_TX;
          end
        end
      end
      ST_BACKOFF: begin
        cmd.runBackoff = 1'b1;
        if (flags.backoffDone) begin
          cmd.clrCca = 1'b1;
          stateN     = ST_CCA;
        end
      end
      ST_CCA: begin
        cmd.runCca = 1'b1;
        if (flags.ccaLast) begin
          if (!flags.chanBusy) begin
            startPulse = 1'b1;
            stateN     = ST_TX;
          end else if (isSched || flags.busyLimit) begin
            finish  = 1'b1;
            finStat = STAT_CHAN;
          end else begin
            cmd.busyStep    = 1'b1;
            cmd.loadBackoff = 1'b1;
            stateN          = ST_BACKOFF;
          end
        end
      end
      ST_TX: begin
        if (phyDone) begin
          if (ackReqR) stateN = ST_ACKWAIT;
          else         finish = 1'b1;
        end
      end
      ST_ACKWAIT: begin
        if (ackRcvd) begin
          finish = 1'b1;
        end else if (ackTimeout) begin
          if (isSched || flags.retryLimit) begin
            finish  = 1'b1;
            finStat = STAT_NOACK;
          end else begin
            cmd.retryStep    = 1'b1;
            cmd.startAttempt = 1'b1;
            cmd.loadBackoff  = 1'b1;
            stateN           = ST_BACKOFF;
          end
        end
      end
      default: stateN = ST_IDLE;
    endcase

    if (usesPhy && !phyGrant) begin
      cmd        = '0;
      startPulse = 1'b0;
      finish     = 1'b1;
      finStat    = STAT_GRANT;
    end
    if (finish) stateN = ST_IDLE;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state       <= ST_IDLE;
      isSched     <= 1'b0;
      ackReqR     <= 1'b0;
      phyStart    <= 1'b0;
      doneIrq     <= 1'b0;
      doneStatus  <= STAT_OK;
      schedErrIrq <= 1'b0;
    end else begin
      state       <= stateN;
      isSched     <= isSchedN;
      ackReqR     <= ackReqN;
      phyStart    <= startPulse;
      doneIrq     <= finish;
      schedErrIrq <= errPulse;
      if (finish) doneStatus <= finStat;
    end
  end

  assign busy    = (state != ST_IDLE);
  assign ackWait = (state == ST_ACKWAIT);

endmodule

// File: rtl/txseq_top.sv
module txseq_top
  import txseq_pkg::*;
#(
  parameter int UNIT_CYCLES = 320,
  parameter int CCA_CYCLES  = 128,
  parameter int BE_MIN      = 3,
  parameter int BE_MAX      = 5,
  parameter int MAX_BUSY    = 4,
  parameter int RETRY_W     = 3,
  parameter int TIME_W      = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               trigNormal,
  input  logic               trigSched,
  input  logic               ackReq,
  input  logic [1:0]         frameVer,
  input  logic [2:0]         ccaMode,
  input  logic               schedCcaEn,
  input  logic               edBusy,
  input  logic               csBusy,
  input  logic               phyGrant,
  input  logic               macBusy,
  input  logic               phyDone,
  input  logic               ackRcvd,
  input  logic               ackTimeout,
  input  logic [TIME_W-1:0]  nowUs,
  input  logic [TIME_W-1:0]  targetUs,
  input  logic [TIME_W-1:0]  minSetupUs,
  input  logic [RETRY_W-1:0] maxRetries,
  output logic               phyStart,
  output logic               ackWait,
  output logic               expectEnhAck,
  output logic               doneIrq,
  output logic [1:0]         doneStatus,
  output logic               schedErrIrq,
  output logic               busy
);

  dpCmd_t  cmd;
  dpFlag_t flags;
  logic    enhKind;

  txseq_ctrl ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .trigNormal (trigNormal),
    .trigSched  (trigSched),
    .ackReq     (ackReq),
    .schedCcaEn (schedCcaEn),
    .phyGrant   (phyGrant),
    .macBusy    (macBusy),
    .phyDone    (phyDone),
    .ackRcvd    (ackRcvd),
    .ackTimeout (ackTimeout),
    .flags      (flags),
    .cmd        (cmd),
    .phyStart   (phyStart),
    .doneIrq    (doneIrq),
    .doneStatus (doneStatus),
    .schedErrIrq(schedErrIrq),
    .busy       (busy),
    .ackWait    (ackWait)
  );

  txseq_dp #(
    .UNIT_CYCLES(UNIT_CYCLES),
    .CCA_CYCLES (CCA_CYCLES),
    .BE_MIN     (BE_MIN),
    .BE_MAX     (BE_MAX),
    .MAX_BUSY   (MAX_BUSY),
    .RETRY_W    (RETRY_W),
    .TIME_W     (TIME_W)
  ) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .cmd       (cmd),
    .frameVer  (frameVer),
    .ccaMode   (ccaMode),
    .edBusy    (edBusy),
    .csBusy    (csBusy),
    .nowUs     (nowUs),
    .targetUs  (targetUs),
    .minSetupUs(minSetupUs),
    .maxRetries(maxRetries),
    .flags     (flags),
    .enhKind   (enhKind)
  );

  assign expectEnhAck = enhKind & busy;

endmodule

// File: rtl/txseq_chk.sv
module txseq_chk (
  input logic       clk,
  input logic       rstN,
  input logic       phyStart,
  input logic       phyGrant,
  input logic       ackWait,
  input logic       doneIrq,
  input logic [1:0] doneStatus,
  input logic       schedErrIrq,
  input logic       busy
);

  a_r4_done_not_err: assert property (@(posedge clk) disable iff (!rstN)
    doneIrq |-> !schedErrIrq);

  a_r4_done_single: assert property (@(posedge clk) disable iff (!rstN)
    doneIrq |=> !doneIrq);

  a_r4_done_idle: assert property (@(posedge clk) disable iff (!rstN)
    doneIrq |-> !busy);

  a_r8_err_quiet: assert property (@(posedge clk) disable iff (!rstN)
    schedErrIrq |-> (!busy && !phyStart));

  a_r5_no_start_in_wait: assert property (@(posedge clk) disable iff (!rstN)
    ackWait |-> !phyStart);

  a_r12_start_granted: assert property (@(posedge clk) disable iff (!rstN)
    phyStart |-> $past(phyGrant));

  a_r12_grant_drop: assert property (@(posedge clk) disable iff (!rstN)
    (ackWait && !phyGrant) |=> (doneIrq && doneStatus == 2'd3));

endmodule

bind txseq_top txseq_chk chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .phyStart   (phyStart),
  .phyGrant   (phyGrant),
  .ackWait    (ackWait),
  .doneIrq    (doneIrq),
  .doneStatus (doneStatus),
  .schedErrIrq(schedErrIrq),
  .busy       (busy)
);

// File: tb/txseq_top_tb_top.sv
module txseq_top_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int UNIT       = 4;
  localparam int CCA        = 3;
  localparam int PHY_LEN    = 5;
  localparam int RESP_DLY   = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        trigNormal = 0, trigSched = 0, ackReq = 0, schedCcaEn = 0;
  logic [1:0]  frameVer = 0;
  logic [2:0]  ccaMode = 3'd2;
  logic        edBusy = 0, csBusy = 0, phyGrant = 1, macBusy = 0;
  logic        phyDone = 0, ackRcvd = 0, ackTimeout = 0;
  logic [31:0] nowUs = 32'd1000, targetUs = 0, minSetupUs = 32'd20;
  logic [2:0]  maxRetries = 3'd3;
  logic        phyStart, ackWait, expectEnhAck, doneIrq, schedErrIrq, busy;
  logic [1:0]  doneStatus;

  int nChecks = 0, nFails = 0;
  int startCnt = 0, doneCnt = 0, errCnt = 0;
  int lastStatus = -1;
  int phyCnt = 0, respCnt = 0, timeoutsLeft = 0;
  bit respOn = 0, manualAck = 0, prevAckWait = 0, sawAckWait = 0;
  bit enhAtWait = 0;
  bit setNowReq = 0;
  logic [31:0] setNowVal = 0;

  txseq_top #(.UNIT_CYCLES(UNIT), .CCA_CYCLES(CCA)) dut_i (
    .clk(clk), .rstN(rstN), .trigNormal(trigNormal), .trigSched(trigSched),
    .ackReq(ackReq), .frameVer(frameVer), .ccaMode(ccaMode),
    .schedCcaEn(schedCcaEn), .edBusy(edBusy), .csBusy(csBusy),
    .phyGrant(phyGrant), .macBusy(macBusy), .phyDone(phyDone),
    .ackRcvd(ackRcvd), .ackTimeout(ackTimeout), .nowUs(nowUs),
    .targetUs(targetUs), .minSetupUs(minSetupUs), .maxRetries(maxRetries),
    .phyStart(phyStart), .ackWait(ackWait), .expectEnhAck(expectEnhAck),
    .doneIrq(doneIrq), .doneStatus(doneStatus), .schedErrIrq(schedErrIrq),
    .busy(busy)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // microsecond clock, one step per cycle
  always @(negedge clk) begin
    if (setNowReq) nowUs <= setNowVal;
    else           nowUs <= nowUs + 32'd1;
  end

  // output monitor
  always @(negedge clk) begin
    if (rstN) begin
      if (phyStart)    startCnt <= startCnt + 1;
      if (doneIrq)     begin doneCnt <= doneCnt + 1; lastStatus <= int'(doneStatus); end
      if (schedErrIrq) errCnt <= errCnt + 1;
      if (ackWait)     sawAckWait <= 1;
    end
  end

  // PHY model
  always @(negedge clk) begin
    phyDone <= 1'b0;
    if (phyStart) phyCnt <= PHY_LEN;
    else if (phyCnt > 0) begin
      phyCnt <= phyCnt - 1;
      if (phyCnt == 1) phyDone <= 1'b1;
    end
  end

  // acknowledgement responder
  always @(negedge clk) begin
    ackRcvd    <= manualAck;
    ackTimeout <= 1'b0;
    if (ackWait && !prevAckWait) begin
      enhAtWait <= expectEnhAck;
      if (respOn) respCnt <= RESP_DLY;
    end else if (respCnt > 0) begin
      respCnt <= respCnt - 1;
      if (respCnt == 1) begin
        if (timeoutsLeft > 0) begin
          ackTimeout   <= 1'b1;
          timeoutsLeft <= timeoutsLeft - 1;
        end else begin
          ackRcvd <= 1'b1;
        end
      end
    end
    prevAckWait <= ackWait;
  end

  task automatic tick();
    @(negedge clk); #1;
  endtask

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic chkRange(input string req, input string what, input longint act,
                          input longint lo, input longint hi);
    nChecks++;
    if (act < lo || act > hi) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d..%0d", req, what, act, lo, hi);
    end
  endtask

  task automatic waitDone(input int maxc, output int took);
    int d0 = doneCnt;
    took = 0;
    while (doneCnt == d0 && took < maxc) begin tick(); took++; end
  endtask

  task automatic pulseNormal();
    trigNormal = 1; tick(); trigNormal = 0;
  endtask

  task automatic pulseSched();
    trigSched = 1; tick(); trigSched = 0;
  endtask

  task automatic setNow(input logic [31:0] v);
    setNowVal = v; setNowReq = 1; tick(); setNowReq = 0;
  endtask

  task automatic tReset();
    chk("R4", "busy after reset", busy, 0);
    chk("R4", "phyStart after reset", phyStart, 0);
    chk("R4", "doneIrq after reset", doneIrq, 0);
    chk("R4", "schedErrIrq after reset", schedErrIrq, 0);
  endtask

  task automatic tClearNoAck();
    for (int n = 0; n < 4; n++) begin
      int s0 = startCnt, lat = 0, took;
      ccaMode = 3'd2; edBusy = 0; csBusy = 0; ackReq = 0; sawAckWait = 0;
      pulseNormal();
      while (startCnt == s0 && lat < 200) begin tick(); lat++; end
      // R1: backoff 0..7 units then one assessment window
      chkRange("R1", "trigger to start latency", lat, CCA, 7*UNIT + CCA + 4);
      waitDone(50, took);
      chk("R6", "status without ack", lastStatus, 0);
      chkRange("R6", "done after phyDone", took, PHY_LEN, PHY_LEN + 2);
      chk("R6", "ackWait seen", sawAckWait, 0);
    end
  endtask

  task automatic tCca(input logic [2:0] m, input logic ed, input logic cs, input bit expBusy);
    int s0 = startCnt, took;
    ccaMode = m; edBusy = ed; csBusy = cs; ackReq = 0;
    pulseNormal();
    waitDone(1000, took);
    if (expBusy) begin
      chk("R2", $sformatf("mode %0d ed %0d cs %0d status", m, ed, cs), lastStatus, 1);
      chk("R3", "starts on busy channel", startCnt - s0, 0);
      chkRange("R3", "channel fail latency", took, 4*CCA, 84*UNIT + 4*(CCA+3) + 4);
    end else begin
      chk("R2", $sformatf("mode %0d ed %0d cs %0d status", m, ed, cs), lastStatus, 0);
      chk("R2", "starts on clear channel", startCnt - s0, 1);
    end
    edBusy = 0; csBusy = 0; ccaMode = 3'd2;
  endtask

  task automatic tAck(input logic [1:0] ver, input bit expEnh);
    int s0 = startCnt, took;
    ackReq = 1; frameVer = ver; respOn = 1; timeoutsLeft = 0;
    pulseNormal();
    waitDone(300, took);
    chk("R7", $sformatf("enhanced kind for version %0d", ver), enhAtWait, expEnh);
    chk("R5", "status with ack", lastStatus, 0);
    chk("R5", "starts with ack", startCnt - s0, 1);
    respOn = 0; ackReq = 0;
  endtask

  task automatic tRetry(input logic [2:0] lim, input int tos, input int expStat, input int expStarts);
    int s0 = startCnt, took;
    ackReq = 1; maxRetries = lim; respOn = 1; timeoutsLeft = tos;
    pulseNormal();
    waitDone(2000, took);
    chk("R5", $sformatf("status limit %0d timeouts %0d", lim, tos), lastStatus, expStat);
    chk("R5", $sformatf("starts limit %0d timeouts %0d", lim, tos), startCnt - s0, expStarts);
    respOn = 0; timeoutsLeft = 0; ackReq = 0; maxRetries = 3;
  endtask

  task automatic tGrantLoss();
    int d0 = doneCnt, w = 0;
    ackReq = 1; respOn = 0;
    pulseNormal();
    while (!ackWait && w < 200) begin tick(); w++; end
    phyGrant = 0;
    tick();
    chk("R12", "done count after grant loss", doneCnt - d0, 1);
    chk("R12", "grant lost status", lastStatus, 3);
    chk("R12", "idle after grant loss", busy, 0);
    phyGrant = 1; ackReq = 0;
  endtask

  task automatic tSchedLate();
    int e0 = errCnt, s0 = startCnt, w = 0, took;
    minSetupUs = 32'd20;
    targetUs = nowUs + 32'd12;
    pulseSched();
    chk("R8", "error for short lead", errCnt - e0, 1);
    chk("R8", "idle after short lead", busy, 0);
    targetUs = nowUs - 32'd5;
    pulseSched();
    chk("R8", "error for past target", errCnt - e0, 2);
    chk("R8", "no start on late", startCnt - s0, 0);
    // lead across wraparound is valid
    setNow(32'hFFFF_FFF0);
    targetUs = 32'h0000_0020;
    ackReq = 0; schedCcaEn = 0;
    pulseSched();
    chk("R8", "no error across wrap", errCnt - e0, 2);
    while (startCnt == s0 && w < 200) begin tick(); w++; end
    chk("R10", "start one step after target", nowUs, 32'h21);
    waitDone(50, took);
    chk("R10", "scheduled status", lastStatus, 0);
  endtask

  task automatic tSchedBlocked(input bit useMac);
    int e0 = errCnt, s0 = startCnt, d0 = doneCnt, w = 0;
    targetUs = nowUs + 32'd40;
    pulseSched();
    if (useMac) macBusy = 1; else phyGrant = 0;
    while (errCnt == e0 && w < 80) begin tick(); w++; end
    chk("R9", useMac ? "error on mac busy" : "error on no grant", errCnt - e0, 1);
    chk("R9", "error at target instant", nowUs, targetUs + 32'd1);
    chk("R9", "no start when blocked", startCnt - s0, 0);
    chk("R9", "no done when blocked", doneCnt - d0, 0);
    macBusy = 0; phyGrant = 1;
  endtask

  task automatic tSchedCca(input logic ed);
    int s0 = startCnt, w = 0, took;
    schedCcaEn = 1; ccaMode = 3'd1; edBusy = ed; ackReq = 0;
    targetUs = nowUs + 32'd30;
    pulseSched();
    if (ed) begin
      waitDone(80, took);
      chk("R10", "scheduled busy status", lastStatus, 1);
      chk("R10", "scheduled busy starts", startCnt - s0, 0);
    end else begin
      while (startCnt == s0 && w < 80) begin tick(); w++; end
      chk("R10", "start after scheduled assessment", nowUs, targetUs + 32'(CCA + 1));
      waitDone(50, took);
      chk("R10", "scheduled clear status", lastStatus, 0);
    end
    schedCcaEn = 0; edBusy = 0; ccaMode = 3'd2;
  endtask

  task automatic tSchedNoRetry();
    int s0 = startCnt, took;
    ackReq = 1; respOn = 1; timeoutsLeft = 5; maxRetries = 3;
    targetUs = nowUs + 32'd30;
    pulseSched();
    waitDone(200, took);
    chk("R11", "scheduled no-ack status", lastStatus, 2);
    chk("R11", "scheduled single start", startCnt - s0, 1);
    respOn = 0; timeoutsLeft = 0; ackReq = 0;
  endtask

  task automatic tIgnore();
    int s0 = startCnt, d0 = doneCnt, e0 = errCnt, w = 0;
    ackReq = 1; respOn = 0;
    pulseNormal();
    while (!ackWait && w < 200) begin tick(); w++; end
    targetUs = nowUs + 32'd30;
    trigNormal = 1; trigSched = 1; tick(); trigNormal = 0; trigSched = 0;
    repeat (50) tick();
    chk("R13", "still waiting after triggers", ackWait, 1);
    manualAck = 1; tick(); manualAck = 0;
    repeat (60) tick();
    chk("R13", "one done only", doneCnt - d0, 1);
    chk("R13", "one start only", startCnt - s0, 1);
    chk("R13", "no schedule error", errCnt - e0, 0);
    ackReq = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual hung run, expected completion");
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (5) tick();
    tReset();
    rstN = 1;
    repeat (3) tick();
    tClearNoAck();
    tCca(3'd1, 1, 0, 1);
    tCca(3'd1, 0, 1, 0);
    tCca(3'd2, 0, 1, 1);
    tCca(3'd2, 1, 0, 0);
    tCca(3'd3, 1, 0, 1);
    tCca(3'd3, 0, 0, 0);
    tCca(3'd4, 1, 0, 0);
    tCca(3'd4, 1, 1, 1);
    tCca(3'd0, 1, 1, 0);
    tAck(2'd0, 0);
    tAck(2'd1, 0);
    tAck(2'd2, 1);
    tRetry(3'd3, 10, 2, 4);
    tRetry(3'd1, 1, 0, 2);
    tRetry(3'd0, 1, 2, 1);
    tGrantLoss();
    repeat (3) tick();
    tSchedLate();
    tSchedBlocked(1);
    tSchedBlocked(0);
    tSchedCca(1);
    tSchedCca(0);
    tSchedNoRetry();
    tIgnore();
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

endmodule